// File: doc/BRIEF.md
# Memory Encryption Key Selector

This block sits between a processor and its external memory controller and makes the per-transaction encryption decision. For every physical address it receives, it takes a run-time number of the most significant address bits as a key identifier and clears them to form the real memory address. It looks the identifier up in a policy table and returns three things: the cleaned address, the 128-bit key to apply, and an encrypt flag. Instead of a result, it returns a deny flag when the identifier is not allowed.

Identifier zero always maps to the platform key, which is supplied by a key generator outside the block. It is the only identifier subject to a single plaintext exclusion window. The other identifiers each carry one of three policies, which are set through a table write port. Activation settings are written once: the base enable, the identifier width, the largest allowed identifier, the algorithm field and the exclusion window. After that they are locked. The cipher engine and key generation are outside the block.

Top module: `mem_key_select`

## Requirements
- R1: A request whose identifier is 0 resolves to `platform_key` with encryption on, unless R4 applies. Table writes addressed to identifier 0 have no effect.
- R2: With N identifier bits active, the identifier is `req_addr[PA_W-1:PA_W-N]` and `rsp_addr` is `req_addr` with those N bits cleared. With N = 0 every request has identifier 0 and `rsp_addr` equals `req_addr`.
- R3: The table policy codes are 2'b01, 2'b10 and 2'b11. Code 2'b01 encrypts with the key written for that identifier. Code 2'b10 encrypts with `platform_key`. Code 2'b11 passes the request in plaintext. Whenever encryption is off, `rsp_key` is zero.
- R4: A request with identifier 0 whose cleaned address satisfies (address AND mask) == base is passed in plaintext. Bits 11:0 of the base and the mask are ignored. Requests with other identifiers are not affected by the window.
- R5: Before a successful activation, or after one with the enable bit low, every response has encrypt 0, deny 0 and key 0, and the address is unchanged.
- R6: An activation write succeeds only under three conditions: the algorithm field equals 4'b0001, the identifier width is at most `MAX_ID_BITS`, and the largest identifier fits within that width. A write that fails any of these raises `act_err` and leaves the block unlocked.
- R7: After the first successful activation write, later activation writes are ignored and raise `act_err`. `act_err` is high for exactly the cycle after the offending write.
- R8: A deny response (`rsp_deny` = 1, encrypt 0, key 0) is given when the identifier exceeds the programmed largest identifier. It is also given when the identifier is nonzero and its table entry was never written (code 2'b00).
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge produces its result at that same edge. While `rsp_valid` is high and `rsp_ready` is low, the result holds its value.
- R10: A table write takes effect at the edge where it is presented. A request accepted at that same edge sees the old entry, and a request accepted at the next edge sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_we | input | 1 | Activation write strobe |
| act_enable | input | 1 | Base encryption enable |
| act_id_bits | input | IDB_W | Number of identifier bits taken from the address top |
| act_max_id | input | MAX_ID_BITS | Largest identifier allowed |
| act_alg | input | 4 | Algorithm select, only 4'b0001 is valid |
| act_excl_base | input | PA_W | Exclusion window base, bits 11:0 ignored |
| act_excl_mask | input | PA_W | Exclusion window mask, bits 11:0 ignored |
| act_err | output | 1 | Activation write rejected or ignored |
| tbl_we | input | 1 | Table write strobe |
| tbl_id | input | MAX_ID_BITS | Identifier to program |
| tbl_policy | input | 2 | Policy code |
| tbl_key | input | 128 | Key for policy 2'b01 |
| platform_key | input | 128 | Key for identifier 0 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | PA_W | Physical address with identifier bits |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_addr | output | PA_W | Address with identifier bits cleared |
| rsp_key | output | 128 | Key to apply, zero when not encrypting |
| rsp_encrypt | output | 1 | Encrypt this transaction |
| rsp_deny | output | 1 | Transaction refused |

## Verification
The result of a request accepted at a rising edge is visible just after that edge. `act_err` shows the outcome of an activation write from the edge that samples it until the next edge. A table write is seen by requests accepted one edge later. The bench drives its inputs 1 ns after each rising edge. On every falling edge it compares the handshake, the error flag and the full result against a behavioural model. That model applies the same edge ordering: it resolves the lookup with the table state as it was before the edge, and only then applies that edge's writes. This makes the same-edge write case and stalls under backpressure fall exactly on the sampled cycle.

// File: rtl/keysel_pkg.sv
package keysel_pkg;
   localparam int KEY_W     = 128;
   localparam int ALG_W     = 4;
   localparam int PAGE_BITS = 12;
   localparam logic [ALG_W-1:0] ALG_XTS = 4'b0001;

   typedef enum logic [1:0] {
      POL_UNSET = 2'b00,
      POL_OWN   = 2'b01,
      POL_PLAT  = 2'b10,
      POL_CLEAR = 2'b11
   } policy_e;
endpackage

// File: rtl/keysel_activation.sv
module keysel_activation
   import keysel_pkg::*;
#(
   parameter int PA_W        = 36,
   parameter int MAX_ID_BITS = 4,
   localparam int IDB_W      = $clog2(MAX_ID_BITS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic                   en_i,
   input  logic [IDB_W-1:0]       idbits_i,
   input  logic [MAX_ID_BITS-1:0] maxid_i,
   input  logic [ALG_W-1:0]       alg_i,
   input  logic [PA_W-1:0]        base_i,
   input  logic [PA_W-1:0]        mask_i,
   output logic                   active_o,
   output logic [IDB_W-1:0]       idbits_o,
   output logic [MAX_ID_BITS-1:0] maxid_o,
   output logic [PA_W-1:0]        base_o,
   output logic [PA_W-1:0]        mask_o,
   output logic                   err_o
);
   logic locked;
   logic settings_ok;

   assign settings_ok = (alg_i == ALG_XTS)
                     && (idbits_i <= IDB_W'(MAX_ID_BITS))
                     && ((maxid_i >> idbits_i) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         active_o <= 1'b0;
         idbits_o <= '0;
         maxid_o  <= '0;
         base_o   <= '0;
         mask_o   <= '0;
         err_o    <= 1'b0;
      end else begin
         err_o <= 1'b0;
         if (we_i) begin
            if (locked || !settings_ok) begin
               err_o <= 1'b1;
            end else begin
               locked   <= 1'b1;
               active_o <= en_i;
               idbits_o <= idbits_i;
               maxid_o  <= maxid_i;
               base_o   <= {base_i[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
               mask_o   <= {mask_i[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            end
         end
      end
   end

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   assert_locked_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && locked) |=> (err_o && $stable(idbits_o) && $stable(active_o)
                            && $stable(maxid_o) && $stable(base_o)));

   assert_reject_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !settings_ok) |=> err_o);
endmodule

// File: rtl/keysel_table.sv
module keysel_table
   import keysel_pkg::*;
#(
   parameter int MAX_ID_BITS = 4,
   localparam int DEPTH      = 1 << MAX_ID_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic [MAX_ID_BITS-1:0] wid_i,
   input  logic [1:0]             wpol_i,
   input  logic [KEY_W-1:0]       wkey_i,
   input  logic [MAX_ID_BITS-1:0] rid_i,
   output logic [1:0]             rpol_o,
   output logic [KEY_W-1:0]       rkey_o
);
   logic [1:0]       pol_arr [DEPTH];
   logic [KEY_W-1:0] key_arr [DEPTH];
   logic             wr_hit;

   // identifier 0 is served by the fixed platform path and never stored
   assign wr_hit = we_i && (wid_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) pol_arr[e] <= 2'(POL_UNSET);
      end else if (wr_hit) begin
         pol_arr[wid_i] <= wpol_i;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_hit) key_arr[wid_i] <= wkey_i;
   end

   assign rpol_o = pol_arr[rid_i];
   assign rkey_o = key_arr[rid_i];

   assert_unwritten_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rid_i == '0) |-> (rpol_o == 2'(POL_UNSET)));
endmodule

// File: rtl/keysel_decode.sv
module keysel_decode
   import keysel_pkg::*;
#(
   parameter int PA_W        = 36,
   parameter int MAX_ID_BITS = 4,
   localparam int IDB_W      = $clog2(MAX_ID_BITS + 1)
) (
   input  logic [PA_W-1:0]        addr_i,
   input  logic                   active_i,
   input  logic [IDB_W-1:0]       idbits_i,
   input  logic [MAX_ID_BITS-1:0] maxid_i,
   input  logic [PA_W-1:0]        base_i,
   input  logic [PA_W-1:0]        mask_i,
   input  logic [KEY_W-1:0]       plat_key_i,
   input  logic [1:0]             tpol_i,
   input  logic [KEY_W-1:0]       tkey_i,
   output logic [MAX_ID_BITS-1:0] id_o,
   output logic [PA_W-1:0]        clean_o,
   output logic [KEY_W-1:0]       key_o,
   output logic                   enc_o,
   output logic                   deny_o
);
   logic in_window;

   always_comb begin
      int nb;
      nb      = active_i ? int'(idbits_i) : 0;
      id_o    = '0;
      clean_o = addr_i;
      for (int j = 0; j < PA_W; j++) begin
         if (j >= PA_W - nb) clean_o[j] = 1'b0;
      end
      for (int i = 0; i < MAX_ID_BITS; i++) begin
         if (i < nb) id_o[i] = addr_i[PA_W - nb + i];
      end
   end

   assign in_window = ((clean_o & mask_i) == base_i);

   always_comb begin
      key_o  = '0;
      enc_o  = 1'b0;
      deny_o = 1'b0;
      if (active_i) begin
         if (id_o > maxid_i) begin
            deny_o = 1'b1;
         end else if (id_o == '0) begin
            if (!in_window) begin
               enc_o = 1'b1;
               key_o = plat_key_i;
            end
         end else begin
            case (policy_e'(tpol_i))
               POL_OWN:   begin enc_o = 1'b1; key_o = tkey_i;     end
               POL_PLAT:  begin enc_o = 1'b1; key_o = plat_key_i; end
               POL_CLEAR: ;
               default:   deny_o = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/mem_key_select.sv
module mem_key_select
   import keysel_pkg::*;
#(
   parameter int PA_W        = 36,
   parameter int MAX_ID_BITS = 4,
   localparam int IDB_W      = $clog2(MAX_ID_BITS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   act_we,
   input  logic                   act_enable,
   input  logic [IDB_W-1:0]       act_id_bits,
   input  logic [MAX_ID_BITS-1:0] act_max_id,
   input  logic [3:0]             act_alg,
   input  logic [PA_W-1:0]        act_excl_base,
   input  logic [PA_W-1:0]        act_excl_mask,
   output logic                   act_err,
   input  logic                   tbl_we,
   input  logic [MAX_ID_BITS-1:0] tbl_id,
   input  logic [1:0]             tbl_policy,
   input  logic [127:0]           tbl_key,
   input  logic [127:0]           platform_key,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [PA_W-1:0]        req_addr,
   output logic                   rsp_valid,
   input  logic                   rsp_ready,
   output logic [PA_W-1:0]        rsp_addr,
   output logic [127:0]           rsp_key,
   output logic                   rsp_encrypt,
   output logic                   rsp_deny
);
   if (MAX_ID_BITS < 1 || MAX_ID_BITS > 15) begin : g_bad_id_bits
      $error("MAX_ID_BITS must lie in 1..15");
   end
   if (PA_W < MAX_ID_BITS + PAGE_BITS + 1) begin : g_bad_pa_w
      $error("PA_W too narrow for identifier and page offset");
   end

   logic                   cur_active;
   logic [IDB_W-1:0]       cur_idbits;
   logic [MAX_ID_BITS-1:0] cur_maxid;
   logic [PA_W-1:0]        cur_base, cur_mask;
   logic [MAX_ID_BITS-1:0] look_id;
   logic [1:0]             look_pol;
   logic [KEY_W-1:0]       look_key;
   logic [PA_W-1:0]        dec_addr;
   logic [KEY_W-1:0]       dec_key;
   logic                   dec_enc, dec_deny;
   logic                   req_fire;

   keysel_activation #(.PA_W(PA_W), .MAX_ID_BITS(MAX_ID_BITS)) u_act (
      .clk(clk), .rst_n(rst_n), .we_i(act_we), .en_i(act_enable),
      .idbits_i(act_id_bits), .maxid_i(act_max_id), .alg_i(act_alg),
      .base_i(act_excl_base), .mask_i(act_excl_mask),
      .active_o(cur_active), .idbits_o(cur_idbits), .maxid_o(cur_maxid),
      .base_o(cur_base), .mask_o(cur_mask), .err_o(act_err)
   );

   keysel_table #(.MAX_ID_BITS(MAX_ID_BITS)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we_i(tbl_we), .wid_i(tbl_id),
      .wpol_i(tbl_policy), .wkey_i(tbl_key), .rid_i(look_id),
      .rpol_o(look_pol), .rkey_o(look_key)
   );

   keysel_decode #(.PA_W(PA_W), .MAX_ID_BITS(MAX_ID_BITS)) u_dec (
      .addr_i(req_addr), .active_i(cur_active), .idbits_i(cur_idbits),
      .maxid_i(cur_maxid), .base_i(cur_base), .mask_i(cur_mask),
      .plat_key_i(platform_key), .tpol_i(look_pol), .tkey_i(look_key),
      .id_o(look_id), .clean_o(dec_addr), .key_o(dec_key),
      .enc_o(dec_enc), .deny_o(dec_deny)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign req_fire  = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_addr    <= '0;
         rsp_key     <= '0;
         rsp_encrypt <= 1'b0;
         rsp_deny    <= 1'b0;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr    <= dec_addr;
            rsp_key     <= dec_key;
            rsp_encrypt <= dec_enc;
            rsp_deny    <= dec_deny;
         end
      end
   end

   assert_result_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> rsp_valid);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_key)
                                     && $stable(rsp_encrypt) && $stable(rsp_deny)));

   assert_deny_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_deny) |-> (!rsp_encrypt && rsp_key == '0));

   assert_inactive_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !cur_active) |=> (!rsp_encrypt && !rsp_deny && rsp_addr == $past(req_addr)));
endmodule

// File: tb/mem_key_select_test.sv
module mem_key_select_test;
   localparam int PA_W  = 36;
   localparam int MAXB  = 4;
   localparam int IDB_W = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             act_we = 0, act_enable = 0;
   logic [IDB_W-1:0] act_id_bits = '0;
   logic [MAXB-1:0]  act_max_id = '0;
   logic [3:0]       act_alg = '0;
   logic [PA_W-1:0]  act_excl_base = '0, act_excl_mask = '0;
   logic             act_err;
   logic             tbl_we = 0;
   logic [MAXB-1:0]  tbl_id = '0;
   logic [1:0]       tbl_policy = '0;
   logic [127:0]     tbl_key = '0;
   logic [127:0]     platform_key = 128'hA5A5_0000_1111_2222_3333_4444_5555_C3C3;
   logic             req_valid = 0, req_ready;
   logic [PA_W-1:0]  req_addr = '0;
   logic             rsp_valid, rsp_ready = 1'b1;
   logic [PA_W-1:0]  rsp_addr;
   logic [127:0]     rsp_key;
   logic             rsp_encrypt, rsp_deny;

   mem_key_select #(.PA_W(PA_W), .MAX_ID_BITS(MAXB)) uut (.*);

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string cur_tag = "R9";

   bit           m_locked, m_active, m_valid, m_err, m_enc, m_deny;
   int           m_nb, m_maxid;
   logic [35:0]  m_base, m_mask, m_addr;
   logic [127:0] m_k;
   logic [1:0]   m_mode [16];
   logic [127:0] m_key [16];

   function automatic void resolve(input logic [35:0] a);
      int nb;
      int id;
      logic [35:0] c;
      nb = m_active ? m_nb : 0;
      id = 0;
      c  = a;
      for (int i = PA_W - nb; i < PA_W; i++) begin
         if (a[i]) id += 1 << (i - (PA_W - nb));
         c[i] = 1'b0;
      end
      m_addr = c; m_k = '0; m_enc = 0; m_deny = 0;
      if (!m_active) return;
      if (id > m_maxid) m_deny = 1;
      else if (id == 0) begin
         if ((c & m_mask) != m_base) begin m_enc = 1; m_k = platform_key; end
      end else begin
         case (m_mode[id])
            2'b01: begin m_enc = 1; m_k = m_key[id]; end
            2'b10: begin m_enc = 1; m_k = platform_key; end
            2'b11: ;
            default: m_deny = 1;
         endcase
      end
   endfunction

   always @(posedge clk) begin
      bit ok;
      if (!rst_n) begin
         m_locked = 0; m_active = 0; m_valid = 0; m_err = 0;
         m_nb = 0; m_maxid = 0; m_base = '0; m_mask = '0;
         for (int e = 0; e < 16; e++) m_mode[e] = 2'b00;
      end else begin
         if (!m_valid || rsp_ready) begin
            m_valid = req_valid;
            if (req_valid) resolve(req_addr);
         end
         m_err = 0;
         if (act_we) begin
            ok = (act_alg == 4'b0001) && (int'(act_id_bits) <= MAXB)
                 && ((int'(act_max_id) >> act_id_bits) == 0);
            if (m_locked || !ok) m_err = 1;
            else begin
               m_locked = 1; m_active = act_enable; m_nb = int'(act_id_bits);
               m_maxid = int'(act_max_id);
               m_base = act_excl_base & ~36'hFFF;
               m_mask = act_excl_mask & ~36'hFFF;
            end
         end
         if (tbl_we && tbl_id != 0) begin
            m_mode[tbl_id] = tbl_policy;
            m_key[tbl_id]  = tbl_key;
         end
      end
   end

   task automatic chk(input string what, input logic [199:0] act, input logic [199:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("handshake/err", 200'({req_ready, rsp_valid, act_err}),
             200'({!m_valid || rsp_ready, m_valid, m_err}));
         if (m_valid && rsp_valid)
            chk("result", 200'({rsp_addr, rsp_key, rsp_encrypt, rsp_deny}),
                200'({m_addr, m_k, m_enc, m_deny}));
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual cycle %0d expected below 50000", cyc);
         summary();
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_req(input logic [35:0] a);
      req_valid = 1; req_addr = a; tick(); req_valid = 0; tick();
   endtask

   task automatic do_act(input bit en, input int nb, input int mx, input logic [3:0] alg,
                         input logic [35:0] b, input logic [35:0] m);
      act_we = 1; act_enable = en; act_id_bits = IDB_W'(nb); act_max_id = MAXB'(mx);
      act_alg = alg; act_excl_base = b; act_excl_mask = m;
      tick(); act_we = 0; tick();
   endtask

   task automatic do_tw(input int id, input logic [1:0] pol, input logic [127:0] k);
      tbl_we = 1; tbl_id = MAXB'(id); tbl_policy = pol; tbl_key = k; tick(); tbl_we = 0;
   endtask

   function automatic logic [35:0] mk(input int id, input logic [32:0] low);
      return {3'(id), low};
   endfunction

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      cur_tag = "R9";
      chk("reset state", 200'({req_ready, rsp_valid, act_err}), 200'(3'b100));

      cur_tag = "R5";
      do_req(36'hF_1234_5678);
      do_req(36'h0_0040_0000);

      cur_tag = "R6";
      do_act(1, 3, 5, 4'b0011, '0, '0);
      do_act(1, 5, 5, 4'b0001, '0, '0);
      do_act(1, 3, 9, 4'b0001, '0, '0);
      do_req(36'hA_0000_1000);

      cur_tag = "R7";
      do_act(1, 3, 5, 4'b0001, 36'h0_0040_0ABC, 36'h1_FFC0_0FFF);
      do_act(1, 2, 3, 4'b0001, '0, '0);

      cur_tag = "R3";
      do_tw(1, 2'b01, 128'h1111_AAAA_0000_0000_0000_0000_0000_0001);
      do_tw(2, 2'b10, 128'hDEAD);
      do_tw(3, 2'b11, 128'hBEEF);
      do_tw(5, 2'b01, 128'h5555_0000_0000_0000_0000_0000_0000_0005);
      cur_tag = "R1";
      do_tw(0, 2'b01, 128'hBAD0);
      do_req(mk(0, 33'h0_0000_1000));
      do_req(mk(0, 33'h1_0000_0000));
      cur_tag = "R3";
      do_req(mk(1, 33'h0_0000_2000));
      do_req(mk(2, 33'h1_2345_6000));
      do_req(mk(3, 33'h0_0000_3000));
      do_req(mk(5, 33'h0_0800_0000));

      cur_tag = "R4";
      do_req(mk(0, 33'h0_0040_1000));
      do_req(mk(0, 33'h0_007F_F123));
      do_req(mk(0, 33'h0_0080_0000));
      do_req(mk(1, 33'h0_0040_1000));
      do_req(mk(3, 33'h0_0040_1000));

      cur_tag = "R2";
      do_req(36'hB_FFFF_FFFF);

      cur_tag = "R8";
      do_req(mk(4, 33'h0_0000_4000));
      do_req(mk(6, 33'h0_0000_4000));
      do_req(mk(7, 33'h0_0040_1000));

      cur_tag = "R10";
      tbl_we = 1; tbl_id = 4; tbl_policy = 2'b01;
      tbl_key = 128'h4444_0000_0000_0000_0000_0000_0000_0004;
      req_valid = 1; req_addr = mk(4, 33'h0_0000_5000);
      tick();
      tbl_we = 0; req_addr = mk(4, 33'h0_0000_6000);
      tick();
      req_valid = 0; tick();

      cur_tag = "R9";
      rsp_ready = 0;
      req_valid = 1; req_addr = mk(1, 33'h0_0000_7000); tick();
      req_addr = mk(2, 33'h0_0000_8000); tick(); tick(); tick();
      rsp_ready = 1; tick();
      req_addr = mk(3, 33'h0_0000_9000); tick();
      req_valid = 0; tick(); tick();

      cur_tag = "R2";
      rst_n = 0; tick(); tick();
      rst_n = 1; tick();
      do_act(1, 0, 0, 4'b0001, 36'hF_0000_0000, 36'hF_0000_0000);
      do_req(36'hE_0000_1000);
      do_req(36'hF_0000_2000);
      cur_tag = "R8";
      do_req(36'h0_0000_3000);

      cur_tag = "R5";
      rst_n = 0; tick(); tick();
      rst_n = 1; tick();
      do_act(0, 3, 5, 4'b0001, '0, '0);
      do_req(mk(2, 33'h0_0000_1000));
      cur_tag = "R7";
      do_act(1, 3, 5, 4'b0001, '0, '0);
      cur_tag = "R5";
      do_req(mk(0, 33'h0_0000_1000));

      tick(); tick();
      summary();
      $finish;
   end
endmodule